// File: doc/BRIEF.md
# Multiplexed Digit Scan and Strobe Generator

This block presents a five-digit BCD conversion result on a shared 4-bit bus, one digit at a time. It lights one digit-enable line per slot, scanning from the most significant digit down to the least, and puts the matching BCD value on the bus for the whole slot. Right after each good conversion it also sends one active-low strobe per digit, so an external latch or a processor can capture the value. It never strobes again until the next conversion arrives.

The block runs from a clock at twice the count rate, so one count is two clock cycles. A strobe of half a count is therefore one clock cycle wide. The first digit slot after a conversion is one count longer than every other slot. A conversion that ends with the overrange flag set blanks the display and stops the scan until the next good result arrives.

Top module: `digit_scan_strobe`

## Requirements
- R1: While `rstN` is low, and right after reset, `digitEn` is all zero, `bcdOut` is zero and `strobeN` is high.
- R2: When `eocPulse` is high with `overRange` low at a rising edge, the block captures `digitsIn`. From the next cycle, `digitEn[4]` (the most significant digit) is the only line high. Later changes on `digitsIn` have no effect until the next `eocPulse`.
- R3: With default parameters, the first most-significant slot after a conversion lasts 402 clocks (201 counts). Every later slot lasts 400 clocks. Slots step `digitEn[4]`, `[3]`, `[2]`, `[1]`, `[0]`.
- R4: While scanning, exactly one `digitEn` bit is high. `bcdOut` equals the captured digit for that line, where digit i sits at `digitsIn[4*i+3:4*i]` (i = 0 is least significant).
- R5: During the first scan after a conversion, `strobeN` is low for exactly one clock in each slot. It falls 202 clocks into the long first slot and 200 clocks into each other slot, which gives five pulses in all. `bcdOut` holds steady while `strobeN` is low.
- R6: After the fifth slot, scanning wraps back to `digitEn[4]` and keeps cycling with 400-clock slots, and `strobeN` stays high.
- R7: An `eocPulse` with `overRange` high blanks the block from the next cycle: `digitEn` is zero, `bcdOut` is zero and `strobeN` is high. It stays that way until a conversion with `overRange` low arrives.
- R8: `overRange` has no effect on the scan when `eocPulse` is low.
- R9: An `eocPulse` during a scan restarts it at `digitEn[4]` with the new digits, a long first slot and a fresh set of five strobes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock at twice the count rate |
| rstN | input | 1 | Asynchronous active-low reset |
| eocPulse | input | 1 | One-cycle end-of-conversion event |
| overRange | input | 1 | Overrange result, sampled with `eocPulse` |
| digitsIn | input | 20 | Five BCD digits; digit i at bits 4i+3..4i |
| digitEn | output | 5 | One-hot digit drive; bit 4 is the most significant digit |
| bcdOut | output | 4 | BCD value of the active digit |
| strobeN | output | 1 | Active-low capture strobe |

## Verification
The main table drives conversions with distinct digit patterns: ascending values, descending values with a zero, an all-equal pattern flagged overrange, and a mostly-zero value. Distinct digits expose a wrong bus-to-line mapping. Equal digits under overrange show that blanking comes from the flag and not from the data. Every clock of the first and second scans is compared against a model of slot lengths and strobe positions. This catches off-by-one slot lengths, a missing long first slot, misplaced strobes and strobes that repeat. Directed runs then cover mid-scan restart, overrange held high without a conversion event, halting in the middle of a scan, and reset during a scan.

// File: rtl/scan_pkg.sv
package scan_pkg;
  // Command strobes from the control to the datapath
  typedef struct packed {
    logic capture;  // latch new digits, go to most significant slot
    logic advance;  // move to the next lower slot (wraps)
    logic halt;     // overrange result: blank everything
    logic run;      // level: scanning is active
  } ctrlStrobes_t;
endpackage

// File: rtl/scan_ctrl.sv
module scan_ctrl
  import scan_pkg::*;
#(
  parameter int SLOT_COUNTS = 200,
  parameter int STROBE_AT   = 100
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         eocPulse,
  input  logic         overRange,
  input  logic         atLsd,
  output ctrlStrobes_t ctl,
  output logic         strobeN
);
  localparam int SLOT_TICKS   = SLOT_COUNTS * 2;
  localparam int LONG_TICKS   = SLOT_TICKS + 2;
  localparam int STROBE_TICK  = STROBE_AT * 2;
  localparam int LSTROBE_TICK = STROBE_TICK + 2;
  localparam int TICK_W       = $clog2(LONG_TICKS);

  logic              running;
  logic              firstScan;
  logic              longSlot;
  logic [TICK_W-1:0] tickCnt;
  logic [TICK_W-1:0] lastTick;
  logic [TICK_W-1:0] strobeTick;
  logic              endSlot;
  logic              goodEoc;
  logic              badEoc;

  assign goodEoc    = eocPulse && !overRange;
  assign badEoc     = eocPulse && overRange;
  assign lastTick   = longSlot ? TICK_W'(LONG_TICKS - 1) : TICK_W'(SLOT_TICKS - 1);
  assign strobeTick = longSlot ? TICK_W'(LSTROBE_TICK) : TICK_W'(STROBE_TICK);
  assign endSlot    = running && !eocPulse && (tickCnt == lastTick);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      running   <= 1'b0;
      firstScan <= 1'b0;
      longSlot  <= 1'b0;
      tickCnt   <= '0;
    end else if (badEoc) begin
      running   <= 1'b0;
      firstScan <= 1'b0;
      longSlot  <= 1'b0;
      tickCnt   <= '0;
    end else if (goodEoc) begin
      running   <= 1'b1;
      firstScan <= 1'b1;
      longSlot  <= 1'b1;
      tickCnt   <= '0;
    end else if (running) begin
      if (endSlot) begin
        tickCnt  <= '0;
        longSlot <= 1'b0;
        if (atLsd) firstScan <= 1'b0;
      end else begin
        tickCnt <= tickCnt + TICK_W'(1);
      end
    end
  end

  always_comb begin
    ctl.capture = goodEoc;
    ctl.advance = endSlot;
    ctl.halt    = badEoc;
    ctl.run     = running;
  end

  assign strobeN = !(running && firstScan && (tickCnt == strobeTick));

  // R5: a strobe is a single clock wide
  p_strobe_width_r5: assert property (@(posedge clk) disable iff (!rstN)
    !strobeN |=> strobeN);
  // R7: an overrange result stops the scan
  p_halt_stops_r7: assert property (@(posedge clk) disable iff (!rstN)
    badEoc |=> !ctl.run);
  // R3: the slot counter never runs past the long slot length
  p_tick_bound_r3: assert property (@(posedge clk) disable iff (!rstN)
    ctl.run |-> (tickCnt < TICK_W'(LONG_TICKS)));
endmodule

// File: rtl/scan_datapath.sv
module scan_datapath
  import scan_pkg::*;
#(
  parameter int NUM_DIGITS = 5,
  parameter int DIGIT_W    = 4
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  ctrlStrobes_t                  ctl,
  input  logic [NUM_DIGITS*DIGIT_W-1:0] digitsIn,
  output logic                          atLsd,
  output logic [NUM_DIGITS-1:0]         digitEn,
  output logic [DIGIT_W-1:0]            bcdOut
);
  localparam int SLOT_W = $clog2(NUM_DIGITS);
  localparam logic [SLOT_W-1:0] MSD_IDX = SLOT_W'(NUM_DIGITS - 1);

  logic [NUM_DIGITS-1:0][DIGIT_W-1:0] held;
  logic [SLOT_W-1:0]                  slot;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      held <= '0;
      slot <= MSD_IDX;
    end else if (ctl.halt) begin
      slot <= MSD_IDX;
    end else if (ctl.capture) begin
      held <= digitsIn;
      slot <= MSD_IDX;
    end else if (ctl.advance) begin
      slot <= (slot == '0) ? MSD_IDX : slot - SLOT_W'(1);
    end
  end

  assign atLsd = (slot == '0);

  for (genvar g = 0; g < NUM_DIGITS; g++) begin : g_drive
    assign digitEn[g] = ctl.run && (slot == SLOT_W'(g));
  end

  assign bcdOut = ctl.run ? held[slot] : '0;

  // R4: exactly one digit line while scanning
  p_onehot_r4: assert property (@(posedge clk) disable iff (!rstN)
    ctl.run |-> ($countones(digitEn) == 1));
  // R2: a capture starts at the most significant digit
  p_capture_msd_r2: assert property (@(posedge clk) disable iff (!rstN)
    ctl.capture |=> digitEn[NUM_DIGITS-1]);
endmodule

// File: rtl/digit_scan_strobe.sv
module digit_scan_strobe
  import scan_pkg::*;
#(
  parameter int NUM_DIGITS  = 5,
  parameter int DIGIT_W     = 4,
  parameter int SLOT_COUNTS = 200,
  parameter int STROBE_AT   = 100
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          eocPulse,
  input  logic                          overRange,
  input  logic [NUM_DIGITS*DIGIT_W-1:0] digitsIn,
  output logic [NUM_DIGITS-1:0]         digitEn,
  output logic [DIGIT_W-1:0]            bcdOut,
  output logic                          strobeN
);
  ctrlStrobes_t ctl;
  logic         atLsd;

  scan_ctrl #(
    .SLOT_COUNTS(SLOT_COUNTS),
    .STROBE_AT  (STROBE_AT)
  ) i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .eocPulse (eocPulse),
    .overRange(overRange),
    .atLsd    (atLsd),
    .ctl      (ctl),
    .strobeN  (strobeN)
  );

  scan_datapath #(
    .NUM_DIGITS(NUM_DIGITS),
    .DIGIT_W   (DIGIT_W)
  ) i_dp (
    .clk     (clk),
    .rstN    (rstN),
    .ctl     (ctl),
    .digitsIn(digitsIn),
    .atLsd   (atLsd),
    .digitEn (digitEn),
    .bcdOut  (bcdOut)
  );

  // R5: data holds steady while the strobe is low
  p_bcd_stable_r5: assert property (@(posedge clk) disable iff (!rstN)
    !strobeN |-> $stable(bcdOut));
  // R7: an overrange conversion blanks the outputs
  p_blank_r7: assert property (@(posedge clk) disable iff (!rstN)
    (eocPulse && overRange) |=> (digitEn == '0 && bcdOut == '0 && strobeN));
  // R9: a good conversion restarts at the top digit without a strobe
  p_restart_r9: assert property (@(posedge clk) disable iff (!rstN)
    (eocPulse && !overRange) |=> (digitEn[NUM_DIGITS-1] && strobeN));
endmodule

// File: tb/test_digit_scan_strobe.sv
module test_digit_scan_strobe;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        eocPulse = 1'b0;
  logic        overRange = 1'b0;
  logic [19:0] digitsIn = '0;
  logic [4:0]  digitEn;
  logic [3:0]  bcdOut;
  logic        strobeN;

  int checks = 0;
  int failures = 0;
  int strobeSeen = 0;
  bit done = 0;

  always #4 clk = ~clk;  // 125 MHz

  digit_scan_strobe i_digit_scan_strobe (
    .clk(clk), .rstN(rstN), .eocPulse(eocPulse), .overRange(overRange),
    .digitsIn(digitsIn), .digitEn(digitEn), .bcdOut(bcdOut), .strobeN(strobeN)
  );

  // {overRange, five digits}
  localparam logic [20:0] VECS [4] = '{
    {1'b0, 20'h12345}, {1'b0, 20'h98760}, {1'b1, 20'h55555}, {1'b0, 20'h00009}
  };

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Expected {digitEn, bcdOut, strobeN} at clock a after a good conversion
  function automatic logic [9:0] model(input int a, input logic [19:0] d);
    int sl;
    bit sb;
    if (a < 402) begin
      sl = 4;
      sb = (a == 202);
    end else begin
      int b = a - 402;
      int s = b / 400;
      sl = ((3 - (s % 5)) + 5) % 5;
      sb = (s < 4) && ((b % 400) == 200);
    end
    return {5'(1 << sl), d[sl*4 +: 4], ~sb};
  endfunction

  // Called at a negedge; leaves the bench at the negedge where the scan is at clock 0
  task automatic pulseEoc(input logic [19:0] d, input logic ovr);
    digitsIn = d; overRange = ovr; eocPulse = 1'b1;
    @(negedge clk);
    eocPulse = 1'b0; overRange = 1'b0; digitsIn = ~d;  // R2: later input is ignored
  endtask

  task automatic walk(input logic [19:0] d, input int first, input int last);
    for (int a = first; a <= last; a++) begin
      logic [9:0] e = model(a, d);
      if (!strobeN) strobeSeen++;
      check(digitEn == e[9:5], (a < 2002) ? "R3 digit order/length" : "R6 wrap order",
            digitEn, e[9:5]);
      check(bcdOut == e[4:1], "R4 bcd matches line", bcdOut, e[4:1]);
      check(strobeN == e[0], (a < 2002) ? "R5 strobe position" : "R6 no strobe",
            strobeN, e[0]);
      @(negedge clk);
    end
  endtask

  task automatic walkIdle(input int n, input string tag);
    for (int a = 0; a < n; a++) begin
      check(digitEn == 5'b0 && bcdOut == 4'b0 && strobeN, tag,
            {digitEn, bcdOut, strobeN}, 10'h001);
      @(negedge clk);
    end
  endtask

  initial begin
    #(8ns * 200000);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    check(digitEn == 0 && bcdOut == 0 && strobeN, "R1 in reset", {digitEn, bcdOut, strobeN}, 10'h001);
    rstN = 1'b1;
    @(negedge clk);
    check(digitEn == 0 && bcdOut == 0 && strobeN, "R1 after reset", {digitEn, bcdOut, strobeN}, 10'h001);

    // Table of conversions
    foreach (VECS[i]) begin
      pulseEoc(VECS[i][19:0], VECS[i][20]);
      if (VECS[i][20]) begin
        walkIdle(500, "R7 overrange blanks");
      end else begin
        strobeSeen = 0;
        walk(VECS[i][19:0], 0, 2801);
        check(strobeSeen == 5, "R5 five strobes", strobeSeen, 5);
      end
    end

    // R9: restart in the middle of a scan
    pulseEoc(20'h24680, 1'b0);
    walk(20'h24680, 0, 900);
    strobeSeen = 0;
    pulseEoc(20'h13579, 1'b0);
    walk(20'h13579, 0, 2101);
    check(strobeSeen == 5, "R9 fresh five strobes", strobeSeen, 5);

    // R8: overrange without a conversion event is ignored
    pulseEoc(20'h31415, 1'b0);
    walk(20'h31415, 0, 299);
    overRange = 1'b1;
    walk(20'h31415, 300, 340);
    overRange = 1'b0;
    walk(20'h31415, 341, 2101);

    // R7: overrange in the middle of a scan halts it, a good result resumes
    pulseEoc(20'h27182, 1'b0);
    walk(20'h27182, 0, 1000);
    pulseEoc(20'h99999, 1'b1);
    walkIdle(900, "R7 halt mid-scan");
    pulseEoc(20'h86420, 1'b0);
    walk(20'h86420, 0, 450);

    // R1: reset during a scan
    rstN = 1'b0;
    @(negedge clk);
    check(digitEn == 0 && bcdOut == 0 && strobeN, "R1 reset mid-scan", {digitEn, bcdOut, strobeN}, 10'h001);
    rstN = 1'b1;
    @(negedge clk);
    walkIdle(50, "R1 idle after reset");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule